// File: doc/BRIEF.md
# Differential capacitance-to-time sequencer

This block is the digital controller of a capacitance-to-time front end. Two comparators watch the voltage on a sensing capacitor and on a reference capacitor while both are charged from matched current sources. The block steps through three phases in a fixed loop: discharge, charge and compare. In the discharge phase it closes the reset switches for a programmable number of cycles. In the charge phase it selects the fast source, which delivers eight times the base current. When the first comparator trips, it falls back to the base current so that the difference interval keeps its full length, and it raises START.

The block then waits for the other comparator. When that one trips it raises STOP, and the phase after that is discharge again. SIGN tells which capacitor is larger, so that a downstream time-to-digital stage always sees START before STOP, whichever capacitor wins. Both comparator outputs are asynchronous. Each passes through a synchronizer and a rising-edge detector before the state machine uses it. A compare phase that never sees STOP ends with a timeout pulse.

Top module: `cts_sequencer`

## Requirements
- R1: While `rst_n` is low, `discharge_o` is 1 and `fast_sel_o`, `start_o`, `stop_o`, `sign_o` and `timeout_o` are 0.
- R2: Each discharge phase holds `discharge_o` high for `reset_cycles_i` clock cycles (a value of 0 counts as 1). In the very next cycle `fast_sel_o` is 1, and it stays 1 for the whole charge phase.
- R3: `fast_sel_o` falls in the same cycle that `start_o` rises, and it stays 0 until the next charge phase.
- R4: A rising edge on either comparator input during the charge phase raises `start_o` on the third rising clock edge after the input changes (two synchronizer stages plus one state register).
- R5: `sign_o` is 1 when the reference comparator trips first, meaning the sensing capacitance is not smaller. It is 0 when the sensing comparator trips first. It is set together with `start_o` and holds its value until the next `start_o`.
- R6: In the compare phase, a rising edge on the comparator that has not yet tripped raises `stop_o` on the third clock edge after that edge. `start_o` and `stop_o` are then high together for exactly one cycle. In the following cycle both are low and `discharge_o` is high.
- R7: If both comparators show their rising edge in the same charge cycle, `start_o` and `stop_o` rise in the same cycle (a zero interval) and `sign_o` is 1.
- R8: If `stop_o` has not risen within `timeout_cycles_i` cycles after `start_o` rose (0 counts as 1), then `timeout_o` pulses for one cycle, exactly that many cycles after `start_o` rose. In that same cycle `start_o` is 0 and `discharge_o` is 1, and `stop_o` is not raised.
- R9: Comparator edges have no effect during the discharge phase. A second rising edge of the comparator that already tripped has no effect during the compare phase. Neither raises `start_o` or `stop_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_cmp_i | input | 1 | Asynchronous comparator output for the sensing capacitor |
| ref_cmp_i | input | 1 | Asynchronous comparator output for the reference capacitor |
| reset_cycles_i | input | CNT_W | Length of the discharge phase in cycles |
| timeout_cycles_i | input | CNT_W | Longest compare phase in cycles before a timeout |
| discharge_o | output | 1 | Closes the capacitor reset switches |
| fast_sel_o | output | 1 | 1 selects the eight-times charging current, 0 the base current |
| start_o | output | 1 | Start of the measured interval |
| stop_o | output | 1 | End of the measured interval |
| sign_o | output | 1 | 1 when the sensing capacitance is not smaller than the reference |
| timeout_o | output | 1 | One-cycle pulse when the compare phase times out |

## Verification
A comparator edge is driven on a falling clock edge in a cycle numbered c. The START or STOP it causes is due in cycle c+3, and a timeout is due `timeout_cycles_i` cycles after START. The end of discharge is due `reset_cycles_i` cycles after `discharge_o` rises. The driver works out each of these cycle numbers when it applies the stimulus and queues it with the expected SIGN. The monitor samples on falling edges, stamps each START rise, STOP rise and timeout pulse with the bench cycle counter, and compares it against the head of the queue, so an early, late, missing or extra event is reported.

// File: rtl/cts_pkg.sv
package cts_pkg;
   typedef enum logic [1:0] {
      PH_DISCHARGE = 2'd0,
      PH_CHARGE    = 2'd1,
      PH_COMPARE   = 2'd2,
      PH_STOPPED   = 2'd3
   } cts_phase_e;
endpackage

// File: rtl/cts_edge_sync.sv
module cts_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   initial begin
      if (STAGES < 2) $error("cts_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] pipe;

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= 1'b0;
            else        pipe[i] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= 1'b0;
            else        pipe[i] <= pipe[i-1];
         end
      end
   end

   assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R4
endmodule

// File: rtl/cts_span_counter.sv
module cts_span_counter #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [W-1:0] limit_i,
   output logic         done_o
);
   initial begin
      if (W < 1) $error("cts_span_counter: W must be at least 1");
   end

   logic [W-1:0] cnt;
   logic [W-1:0] last;

   assign last   = (limit_i == '0) ? '0 : limit_i - W'(1);
   assign done_o = (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr_i)   cnt <= '0;
      else if (!done_o) cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/cts_phase_fsm.sv
module cts_phase_fsm
   import cts_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rise_sen_i,
   input  logic       rise_ref_i,
   input  logic       span_done_i,
   output logic       span_clr_o,
   output cts_phase_e phase_o,
   output logic       discharge_o,
   output logic       fast_sel_o,
   output logic       start_o,
   output logic       stop_o,
   output logic       sign_o,
   output logic       timeout_o
);
   cts_phase_e state, nxt;
   logic       sign_q, tmo_q;
   logic       waited_rise;
   logic       first_rise;

   assign first_rise  = rise_sen_i | rise_ref_i;
   // sign 1 means the reference tripped first, so the sensing side is awaited
   assign waited_rise = sign_q ? rise_sen_i : rise_ref_i;

   always_comb begin
      nxt = state;
      unique case (state)
         PH_DISCHARGE: if (span_done_i) nxt = PH_CHARGE;
         PH_CHARGE: begin
            if (rise_sen_i && rise_ref_i) nxt = PH_STOPPED;
            else if (first_rise)          nxt = PH_COMPARE;
         end
         PH_COMPARE: begin
            if (waited_rise)      nxt = PH_STOPPED;
            else if (span_done_i) nxt = PH_DISCHARGE;
         end
         PH_STOPPED: nxt = PH_DISCHARGE;
         default:    nxt = PH_DISCHARGE;
      endcase
   end

   assign span_clr_o = (nxt != state);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= PH_DISCHARGE;
         sign_q <= 1'b0;
         tmo_q  <= 1'b0;
      end else begin
         state <= nxt;
         if (state == PH_CHARGE && first_rise) sign_q <= rise_ref_i;
         tmo_q <= (state == PH_COMPARE) && !waited_rise && span_done_i;
      end
   end

   assign phase_o     = state;
   assign discharge_o = (state == PH_DISCHARGE);
   assign fast_sel_o  = (state == PH_CHARGE);
   assign start_o     = (state == PH_COMPARE) || (state == PH_STOPPED);
   assign stop_o      = (state == PH_STOPPED);
   assign sign_o      = sign_q;
   assign timeout_o   = tmo_q;

   AST_FAST_AFTER_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fast_sel_o) |-> $past(discharge_o)); // R2
   AST_FAST_OFF_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_o) |-> (!fast_sel_o && $past(fast_sel_o))); // R3
   AST_SIGN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o && $past(start_o)) |-> $stable(sign_o)); // R5
   AST_STOP_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |-> start_o); // R6
   AST_STOP_THEN_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |=> (discharge_o && !start_o && !stop_o)); // R6
   AST_TIE_ZERO_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_CHARGE && rise_sen_i && rise_ref_i) |=> (stop_o && sign_o)); // R7
   AST_TIMEOUT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (discharge_o && $past(start_o) && !$past(stop_o))); // R8
   AST_NO_START_IN_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      discharge_o |=> !start_o); // R9
endmodule

// File: rtl/cts_sequencer.sv
module cts_sequencer
   import cts_pkg::*;
#(
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FAST_RATIO  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sen_cmp_i,
   input  logic             ref_cmp_i,
   input  logic [CNT_W-1:0] reset_cycles_i,
   input  logic [CNT_W-1:0] timeout_cycles_i,
   output logic             discharge_o,
   output logic             fast_sel_o,
   output logic             start_o,
   output logic             stop_o,
   output logic             sign_o,
   output logic             timeout_o
);
   initial begin
      if (FAST_RATIO < 2) $error("cts_sequencer: FAST_RATIO must exceed 1");
   end

   logic       rise_sen, rise_ref;
   logic       span_clr, span_done;
   logic [CNT_W-1:0] span_limit;
   cts_phase_e phase;

   cts_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_sen (
      .clk(clk), .rst_n(rst_n), .async_i(sen_cmp_i), .rise_o(rise_sen));

   cts_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_ref (
      .clk(clk), .rst_n(rst_n), .async_i(ref_cmp_i), .rise_o(rise_ref));

   assign span_limit = (phase == PH_COMPARE) ? timeout_cycles_i : reset_cycles_i;

   cts_span_counter #(.W(CNT_W)) i_span (
      .clk(clk), .rst_n(rst_n), .clr_i(span_clr),
      .limit_i(span_limit), .done_o(span_done));

   cts_phase_fsm i_fsm (
      .clk(clk), .rst_n(rst_n),
      .rise_sen_i(rise_sen), .rise_ref_i(rise_ref),
      .span_done_i(span_done), .span_clr_o(span_clr),
      .phase_o(phase),
      .discharge_o(discharge_o), .fast_sel_o(fast_sel_o),
      .start_o(start_o), .stop_o(stop_o),
      .sign_o(sign_o), .timeout_o(timeout_o));
endmodule

// File: tb/test_cts_sequencer.sv
module test_cts_sequencer;
   localparam int W = 12;

   logic clk = 1'b0;
   logic rst_n;
   logic sen_cmp, ref_cmp;
   logic [W-1:0] rst_len, tmo_len;
   logic discharge, fast_sel, start, stop, sign, timeout;

   always #4 clk = ~clk;

   cts_sequencer #(.CNT_W(W)) i_cts_sequencer (
      .clk(clk), .rst_n(rst_n), .sen_cmp_i(sen_cmp), .ref_cmp_i(ref_cmp),
      .reset_cycles_i(rst_len), .timeout_cycles_i(tmo_len),
      .discharge_o(discharge), .fast_sel_o(fast_sel), .start_o(start),
      .stop_o(stop), .sign_o(sign), .timeout_o(timeout));

   typedef struct {
      int    kind;  // 0 start, 1 stop, 2 timeout
      int    cyc;
      bit    sgn;
      string req;
   } ev_t;

   ev_t   q[$];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    p_start = 1'b0, p_stop = 1'b0;
   bit    finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic expect_ev(int kind, int at, bit sgn, string req);
      ev_t e;
      e.kind = kind; e.cyc = at; e.sgn = sgn; e.req = req;
      q.push_back(e);
   endtask

   task automatic pop_cmp(int kind);
      ev_t e;
      if (q.size() == 0) begin
         check(1'b0, "R9", "unexpected event kind", kind, -1);
         return;
      end
      e = q.pop_front();
      check(e.kind == kind, e.req, "event kind", kind, e.kind);
      check(e.cyc == cyc, e.req, "event cycle", cyc, e.cyc);
      if (kind != 2) check(sign == e.sgn, e.req, "sign at event", sign, e.sgn);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (start && !p_start) pop_cmp(0);
         if (stop && !p_stop)   pop_cmp(1);
         if (timeout)           pop_cmp(2);
      end
      p_start = start;
      p_stop  = stop;
   end

   task automatic fire_first(bit use_ref, string req);
      @(negedge clk);
      if (use_ref) ref_cmp = 1'b1; else sen_cmp = 1'b1;
      expect_ev(0, cyc + 3, use_ref, req);
   endtask

   task automatic fire_second(bit sgn, string req);
      @(negedge clk);
      if (sgn) sen_cmp = 1'b1; else ref_cmp = 1'b1;
      expect_ev(1, cyc + 3, sgn, req);
   endtask

   task automatic wait_discharge();
      while (!discharge) @(negedge clk);
   endtask

   task automatic wait_charge();
      while (!fast_sel) @(negedge clk);
   endtask

   task automatic measure_discharge(int exp, string req);
      int n = 0;
      while (discharge) begin
         n++;
         @(negedge clk);
      end
      check(n == exp, req, "discharge length", n, exp);
      check(fast_sel == 1'b1, req, "fast select after discharge", fast_sel, 1);
   endtask

   task automatic end_cycle(int len, string req);
      wait_discharge();
      check(start == 1'b0, req, "start low in discharge", start, 0);
      sen_cmp = 1'b0;
      ref_cmp = 1'b0;
      measure_discharge(len, req);
   endtask

   initial begin
      rst_n = 1'b0; sen_cmp = 1'b0; ref_cmp = 1'b0;
      rst_len = W'(4); tmo_len = W'(20);
      repeat (3) @(negedge clk);
      check(discharge == 1'b1, "R1", "discharge in reset", discharge, 1);
      check({fast_sel, start, stop, sign, timeout} == 5'b0, "R1", "outputs in reset",
            {fast_sel, start, stop, sign, timeout}, 0);
      rst_n = 1'b1;
      measure_discharge(4, "R2");

      // sensor larger: reference trips first
      fire_first(1'b1, "R4");
      repeat (4) @(negedge clk);
      check(fast_sel == 1'b0, "R3", "base current in compare", fast_sel, 0);
      check(sign == 1'b1, "R5", "sign ref first", sign, 1);
      fire_second(1'b1, "R6");
      end_cycle(4, "R6");

      // sensor smaller: sensing trips first, shorter reset next
      fire_first(1'b0, "R5");
      rst_len = W'(1);
      repeat (2) @(negedge clk);
      fire_second(1'b0, "R6");
      end_cycle(1, "R2");

      // both in the same cycle
      rst_len = W'(4);
      @(negedge clk);
      sen_cmp = 1'b1; ref_cmp = 1'b1;
      expect_ev(0, cyc + 3, 1'b1, "R7");
      expect_ev(1, cyc + 3, 1'b1, "R7");
      end_cycle(4, "R7");

      // timeout, reference left high through the next discharge
      fire_first(1'b1, "R8");
      expect_ev(2, cyc + 3 + 20, 1'b1, "R8");
      wait_discharge();
      check(start == 1'b0, "R8", "start low after timeout", start, 0);
      measure_discharge(4, "R8");

      // level held from before charge gives no start
      repeat (10) @(negedge clk);
      check(start == 1'b0, "R9", "no start from held level", start, 0);
      check(fast_sel == 1'b1, "R9", "still charging", fast_sel, 1);
      ref_cmp = 1'b0;
      repeat (3) @(negedge clk);
      fire_first(1'b1, "R4");
      repeat (4) @(negedge clk);
      ref_cmp = 1'b0;
      repeat (3) @(negedge clk);
      ref_cmp = 1'b1;
      repeat (6) @(negedge clk);
      check(stop == 1'b0, "R9", "repeat edge ignored", stop, 0);
      fire_second(1'b1, "R6");
      end_cycle(4, "R6");

      // shortest timeout
      tmo_len = W'(1);
      fire_first(1'b0, "R8");
      expect_ev(2, cyc + 3 + 1, 1'b0, "R8");
      end_cycle(4, "R8");

      // one-cycle interval
      tmo_len = W'(20);
      fire_first(1'b1, "R4");
      fire_second(1'b1, "R6");
      end_cycle(4, "R6");

      repeat (5) @(negedge clk);
      check(q.size() == 0, "R6", "pending expected events", q.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL R1 watchdog expired: actual %0d expected %0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule